// File: doc/BRIEF.md
# I2C Register-File Target with Pointer Auto-Increment

This block is a synthesizable I2C target that sits on oversampled bus lines. SCL and SDA arrive as plain inputs and pass through a synchroniser running on the system clock. The target pulls SDA low through a single open-drain enable output. Its 7-bit bus address is built from a parameter that gives the five upper bits and two strap inputs that give the two lower bits. The same block can therefore appear up to four times on one bus.

After its address with a write direction, the target takes a control byte. That byte carries a 4-bit register pointer, an auto-increment enable and a 2-bit auto-increment range. Each further data byte goes into a 13-entry file of 8-bit registers at the pointer. A read transaction returns register contents starting at the pointer. The pointer steps through a fixed sequence whenever auto-increment is on. The whole file is presented on a flat parallel output, so neighbouring logic can use the values directly.

Top module: `i2c_regfile_target`

## Requirements
- R1: An SDA fall while SCL is high (START) abandons any partial byte and restarts address reception. An SDA rise while SCL is high (STOP) returns the target to idle with SDA released.
- R2: The address byte is `{ADDR_UPPER[4:0], strap_a[1:0], rw}`, sent MSB first, with rw=0 for write. On a match the target holds SDA low for the high phase of the ninth clock. On a mismatch it does not acknowledge, and it ignores the bus until the next START: no register changes and no SDA drive.
- R3: Data bits are taken on SCL rising edges, MSB first. The target changes its SDA drive only after an SCL falling edge, so SDA changes during SCL high are never read as data.
- R4: In the control byte, bit 7 enables auto-increment, bits 6:5 select the range and bits 3:0 load the pointer. Bit 4 is unused. The control byte is acknowledged.
- R5: Every data byte of a write is acknowledged and stored at the pointer. Register k appears on `regs_o[8k+7:8k]`, and all registers reset to 0x00.
- R6: With auto-increment off, the pointer holds its value, so successive data bytes overwrite the same register.
- R7: With auto-increment on and range 00, the pointer steps 0,1,…,12 and then back to 0. Any pointer of 12 or above steps to 0.
- R8: The other ranges cycle through a sub-block of the file. Range 01 covers 2..5, range 10 covers 6..8 and range 11 covers 2..8. A pointer at or above the range's top steps to the range's bottom.
- R9: A write at a pointer of 13 to 15 is acknowledged but changes no register. The pointer still advances by R6 to R8.
- R10: In a read, the target sends the register at the pointer, MSB first, driving SDA low only for 0 bits. Pointers 13 to 15 read as 0x00. After each byte the pointer advances by the R6 to R8 rules, and a master ACK starts the next byte.
- R11: A master NACK after a read byte ends the transfer. The target releases SDA and does not drive it again before the next START.
- R12: There is no limit on the number of data bytes between START and STOP. Long bursts keep wrapping by the range rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_a | input | 2 | Strap pins giving the two lowest address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Register file contents, register k at bits 8k+7:8k |

## Verification
The hardest states to reach from the ports are the pointer boundary cases. These are a pointer sitting above the file or above a sub-range, and that same pointer then wrapping to the range start in the middle of a burst. The bench gets there with control bytes that pick random ranges and random start pointers, including values 13 to 15. Each is followed by random-length bursts, and every result is compared to a bench model of the stepping rule. A repeated START that cuts a byte after four bits, and a read that ends in a NACK followed by extra clock pulses, cover the abort and release paths.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CTRL,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  // lowest pointer of an auto-increment range
  function automatic logic [3:0] range_lo(input logic [1:0] mode);
    case (mode)
      2'b00:   range_lo = 4'd0;
      2'b01:   range_lo = 4'd2;
      2'b10:   range_lo = 4'd6;
      default: range_lo = 4'd2;
    endcase
  endfunction

  // highest pointer of an auto-increment range
  function automatic logic [3:0] range_hi(input logic [1:0] mode, input logic [3:0] last);
    case (mode)
      2'b00:   range_hi = last;
      2'b01:   range_hi = 4'd5;
      default: range_hi = 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] step_ptr(input logic [3:0] p, input logic [1:0] mode,
                                          input logic [3:0] last);
    if (p >= range_hi(mode, last)) step_ptr = range_lo(mode);
    else                           step_ptr = p + 4'd1;
  endfunction

  function automatic logic addr_hit(input logic [6:0] rx, input logic [4:0] upper,
                                    input logic [1:0] strap);
    addr_hit = (rx == {upper, strap});
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] pins;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign pins = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q   <= '1;
        prev_q[g] <= 1'b1;
      end else begin
        chain_q   <= {chain_q[STAGES-2:0], pins[g]};
        prev_q[g] <= chain_q[STAGES-1];
      end
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = scl_s & ~prev_q[0];
  assign scl_fall  = ~scl_s & prev_q[0];
  assign start_evt = scl_s & prev_q[0] & prev_q[1] & ~sda_s;
  assign stop_evt  = scl_s & prev_q[0] & ~prev_q[1] & sda_s;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_rf_pkg::*;
#(
  parameter logic [4:0] ADDR_UPPER = 5'b10110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_s,
  input  logic [1:0] strap,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic       ctrl_load,
  output logic       rd_adv,
  output logic [7:0] byte_q,
  output phase_t     phase
);
  localparam logic [3:0] FULL = 4'd8;

  logic [3:0] bitcnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       in_ack;
  logic       rw_q;
  logic       mack_q;
  logic       rx_phase;

  assign rx_phase = (phase == PH_ADDR) || (phase == PH_CTRL) || (phase == PH_WDATA);
  assign byte_q   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      in_ack    <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      ctrl_load <= 1'b0;
      rd_adv    <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      ctrl_load <= 1'b0;
      rd_adv    <= 1'b0;
      if (start_evt) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (rx_phase) begin
        if (in_ack) begin
          if (scl_fall) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            if (phase == PH_ADDR) begin
              if (rw_q) begin
                phase  <= PH_RDATA;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                phase <= PH_CTRL;
              end
            end else if (phase == PH_CTRL) begin
              phase <= PH_WDATA;
            end
          end
        end else if (scl_rise && bitcnt != FULL) begin
          rx_sh  <= {rx_sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == FULL) begin
          if (phase == PH_ADDR) begin
            if (addr_hit(rx_sh[7:1], ADDR_UPPER, strap)) begin
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              rw_q   <= rx_sh[0];
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            sda_oe <= 1'b1;
            in_ack <= 1'b1;
            if (phase == PH_CTRL) ctrl_load <= 1'b1;
            else                  wr_en     <= 1'b1;
          end
        end
      end else if (phase == PH_RDATA) begin
        if (!in_ack) begin
          if (scl_rise && bitcnt != FULL) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == FULL) begin
            sda_oe <= 1'b0;
            in_ack <= 1'b1;
            rd_adv <= 1'b1;
          end else if (scl_fall && bitcnt != 4'd0) begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
          end
        end else begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (mack_q) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              phase  <= PH_IDLE;
              sda_oe <= 1'b0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store
  import i2c_rf_pkg::*;
#(
  parameter int NUM_REGS = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  ctrl_load,
  input  logic                  rd_adv,
  input  logic [7:0]            wr_byte,
  output logic [3:0]            ptr,
  output logic                  ai_en,
  output logic [1:0]            ai_mode,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] file_o
);
  localparam logic [3:0] LAST = 4'(NUM_REGS - 1);

  logic [NUM_REGS*8-1:0] file_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      file_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if ({1'b0, ptr} == 5'(k)) file_q[k*8 +: 8] <= wr_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      ai_en   <= 1'b0;
      ai_mode <= '0;
    end else if (ctrl_load) begin
      ai_en   <= wr_byte[7];
      ai_mode <= wr_byte[6:5];
      ptr     <= wr_byte[3:0];
    end else if ((wr_en || rd_adv) && ai_en) begin
      ptr <= step_ptr(ptr, ai_mode, LAST);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_REGS; k++) begin
      if ({1'b0, ptr} == 5'(k)) rd_data = file_q[k*8 +: 8];
    end
  end

  assign file_o = file_q;

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_rf_pkg::*;
#(
  parameter logic [4:0] ADDR_UPPER  = 5'b10110,
  parameter int         NUM_REGS    = 13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [1:0]            strap_a,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;
  logic       wr_en;
  logic       ctrl_load;
  logic       rd_adv;
  logic [7:0] byte_q;
  logic [7:0] rd_data;
  logic [3:0] ptr;
  logic       ai_en;
  logic [1:0] ai_mode;
  phase_t     phase;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_byte_engine #(.ADDR_UPPER(ADDR_UPPER)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s), .strap(strap_a),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .wr_en(wr_en), .ctrl_load(ctrl_load),
    .rd_adv(rd_adv), .byte_q(byte_q), .phase(phase)
  );

  i2c_reg_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_load(ctrl_load), .rd_adv(rd_adv),
    .wr_byte(byte_q), .ptr(ptr), .ai_en(ai_en), .ai_mode(ai_mode),
    .rd_data(rd_data), .file_o(regs_o)
  );

endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk
  import i2c_rf_pkg::*;
#(
  parameter int NUM_REGS = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  scl_fall,
  input logic                  sda_oe_o,
  input phase_t                phase,
  input logic                  wr_en,
  input logic [3:0]            ptr,
  input logic                  ai_en,
  input logic [1:0]            ai_mode,
  input logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [3:0] LAST = 4'(NUM_REGS - 1);
  localparam logic [4:0] NREG = 5'(NUM_REGS);

  a_r1_start_enters_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_ADDR));

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe_o && phase == PH_IDLE));

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe_o);

  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  a_r6_ptr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ai_en) |=> $stable(ptr));

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ai_en && ai_mode == 2'b00 && ptr == LAST) |=> (ptr == 4'd0));

  a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && {1'b0, ptr} >= NREG) |=> $stable(regs_o));

endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .scl_fall(scl_fall), .sda_oe_o(sda_oe_o), .phase(phase), .wr_en(wr_en),
  .ptr(ptr), .ai_en(ai_en), .ai_mode(ai_mode), .regs_o(regs_o)
);

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;
  localparam logic [4:0] UPPER = 5'b10110;
  localparam int NR = 13;
  localparam int Q  = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scl_m = 1'b1;
  logic            sda_m = 1'b1;
  logic [1:0]      strap = 2'b10;
  logic            sda_oe;
  logic [NR*8-1:0] regs_o;
  wire             sda_line = sda_m & ~sda_oe;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [7:0] m_regs [NR];
  logic [3:0] m_ptr;
  logic       m_ai;
  logic [1:0] m_mode;

  always #5 clk = ~clk;

  i2c_regfile_target #(.ADDR_UPPER(UPPER), .NUM_REGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_a(strap), .sda_oe_o(sda_oe), .regs_o(regs_o)
  );

  // ---------------- bench model ----------------
  function automatic logic [3:0] b_next(input logic [3:0] p, input logic [1:0] m);
    int top, bot;
    case (m)
      2'b00: begin bot = 0; top = NR - 1; end
      2'b01: begin bot = 2; top = 5; end
      2'b10: begin bot = 6; top = 8; end
      default: begin bot = 2; top = 8; end
    endcase
    return (int'(p) < top) ? p + 4'd1 : 4'(bot);
  endfunction

  task automatic model_ctrl(input logic [7:0] b);
    m_ai = b[7]; m_mode = b[6:5]; m_ptr = b[3:0];
  endtask

  task automatic model_write(input logic [7:0] b);
    if (int'(m_ptr) < NR) m_regs[m_ptr] = b;
    if (m_ai) m_ptr = b_next(m_ptr, m_mode);
  endtask

  task automatic model_read(output logic [7:0] b);
    b = (int'(m_ptr) < NR) ? m_regs[m_ptr] : 8'h00;
    if (m_ai) m_ptr = b_next(m_ptr, m_mode);
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NR; k++) chk(req, 32'(regs_o[k*8 +: 8]), 32'(m_regs[k]));
  endtask

  // ---------------- bus master ----------------
  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    ack = ~sda_line;
    wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic rw);
    return {UPPER, strap, rw};
  endfunction

  task automatic do_write(input logic [7:0] ctrl, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(addr_byte(1'b0), ack); chk("R2 address ack", 32'(ack), 1);
    send_byte(ctrl, ack);            chk("R4 control ack", 32'(ack), 1);
    model_ctrl(ctrl);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk("R5 data ack", 32'(ack), 1);
      model_write(d);
    end
    bus_stop;
    chk_regs(req);
  endtask

  task automatic do_read(input logic [7:0] ctrl, input int n, input string req);
    logic ack;
    logic [7:0] got, exp;
    bus_start;
    send_byte(addr_byte(1'b0), ack); chk("R10 address ack", 32'(ack), 1);
    send_byte(ctrl, ack);            chk("R10 control ack", 32'(ack), 1);
    model_ctrl(ctrl);
    bus_start;
    send_byte(addr_byte(1'b1), ack); chk("R10 read address ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, got);
      model_read(exp);
      chk(req, 32'(got), 32'(exp));
    end
    // R11: after the NACK the line must stay released through extra clocks
    begin
      int held = 0;
      for (int i = 0; i < 9; i++) begin
        wq(1); scl_m = 1'b1; wq(1);
        if (sda_line !== 1'b1 || sda_oe !== 1'b0) held++;
        wq(1); scl_m = 1'b0;
      end
      wq(1);
      chk("R11 released after NACK", 32'(held), 0);
    end
    bus_stop;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic ack;
    void'($urandom(32'h5eed_1c2c));
    for (int k = 0; k < NR; k++) m_regs[k] = 8'h00;
    m_ptr = 0; m_ai = 0; m_mode = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R5 reset registers", 32'(regs_o == '0), 1);
    chk("R1 reset SDA released", 32'(sda_oe), 0);

    // R2: wrong address, then bytes that must be ignored
    bus_start;
    send_byte({5'b10111, strap, 1'b0}, ack); chk("R2 mismatch NACK", 32'(ack), 0);
    send_byte(8'h80, ack);                   chk("R2 ignored byte NACK", 32'(ack), 0);
    send_byte(8'hA5, ack);                   chk("R2 ignored data NACK", 32'(ack), 0);
    bus_stop;
    chk_regs("R2 no write after mismatch");

    // R7/R5/R3: fill the whole file and wrap
    do_write(8'h80, NR + 2, "R7 full auto-increment wrap");

    // R6: auto-increment off overwrites one register
    do_write(8'h03, 3, "R6 fixed pointer overwrite");

    // R9: out-of-range pointer, then wrap into register 0
    do_write(8'h0E, 2, "R9 pointer 14 ignored");
    do_write(8'h8D, 2, "R9 pointer 13 ignored then wrap");

    // R8: random ranges and start pointers
    for (int it = 0; it < 8; it++) begin
      logic [7:0] c;
      c = {1'b1, 2'($urandom), 1'b0, 4'($urandom)};
      do_write(c, 1 + int'($urandom % 8), "R8 range auto-increment");
    end

    // R12: long burst
    do_write(8'h80, 30, "R12 long burst");

    // R10/R11: reads
    do_read(8'h80, 4, "R10 read from 0");
    do_read(8'hA4, 6, "R10 read range 01");
    do_read(8'h0F, 2, "R10 read pointer 15 gives 00");
    do_read(8'h8B, 4, "R10 read wrap");

    // R1: repeated START aborts a partial byte
    bus_start;
    send_byte(addr_byte(1'b0), ack); chk("R1 address ack", 32'(ack), 1);
    send_byte(8'h05, ack);           chk("R1 control ack", 32'(ack), 1);
    model_ctrl(8'h05);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start;
    send_byte(addr_byte(1'b0), ack); chk("R1 address after restart", 32'(ack), 1);
    send_byte(8'h06, ack);           model_ctrl(8'h06);
    send_byte(8'h3C, ack);           model_write(8'h3C);
    bus_stop;
    chk_regs("R1 partial byte discarded");
    chk("R1 stop releases SDA", 32'(sda_oe), 0);

    // R2: straps change the address
    strap = 2'b01;
    wq(2);
    bus_start;
    send_byte({UPPER, 2'b10, 1'b0}, ack); chk("R2 old strap NACK", 32'(ack), 0);
    bus_stop;
    do_write(8'h09, 1, "R2 new strap write");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule